// File: doc/BRIEF.md
# CCD Shift-Gate Pulse Generator

This block drives the 24 vertical outputs of an interline CCD timing path. Each output either forwards an ordinary vertical-transfer waveform supplied on `xv_in`, or becomes a shift-gate output. A shift-gate output rests at a programmed start level. On a chosen line of the field it inverts for a window of pixel positions, which moves the pixel charge from the photosites into the shielded vertical registers.

The block counts pixels within a line and lines within a field. The counts are referenced to the line sync `hd` and the field sync `vd`, which are one-cycle pulses on the pixel clock. There are four shared toggle positions, and each output picks one pair of them. There are two active-line numbers, and a per-output mask removes chosen pulses from a field. All configuration is captured as the field starts, so software may rewrite it at any time without corrupting the field in progress.

Top module: `sg_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `v_out` is all zero.
- R2: An output whose captured select bit is 0 presents `xv_in` of that bit on `v_out` exactly one clock later.
- R3: An output whose captured select bit is 1 holds its captured start level `cfg_pol` on every line whose number matches neither active-line value.
- R4: On an active line, an unmasked shift-gate output is inverted from its start level for the pixel counts p with ta <= p < tb. Pattern bit 0 takes ta = `cfg_tog1` and tb = `cfg_tog2`. Pattern bit 1 takes ta = `cfg_tog3` and tb = `cfg_tog4`. The level seen on `v_out` for count p appears one clock after the counter holds p.
- R5: Inversion occurs on line `cfg_line_a` and again on line `cfg_line_b`. When the two values are equal, only one pulse is produced in the field.
- R6: A shift-gate output whose captured mask bit is 1 holds its start level for the whole field.
- R7: All `cfg_*` inputs are captured only in a cycle where `vd` is high. Changes made at other times affect `v_out` only from the next field.
- R8: The pixel count is 0 in the cycle after `hd` is high and increments by one each cycle otherwise. The line count is 0 in the cycle after `vd` is high and increments by one in the cycle after each other `hd` pulse.
- R9: When the selected first toggle value is not below the second, the output never inverts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd | input | 1 | Line-start pulse, one cycle |
| vd | input | 1 | Field-start pulse, one cycle, coincident with `hd` |
| xv_in | input | 24 | Vertical-transfer waveforms, bit i for output i+1 |
| cfg_sel | input | 24 | 1 makes the output a shift-gate output |
| cfg_pat | input | 24 | Toggle-pair choice: 0 uses toggles 1/2, 1 uses toggles 3/4 |
| cfg_mask | input | 24 | 1 suppresses the shift-gate pulse for the field |
| cfg_pol | input | 24 | Start level of each shift-gate output |
| cfg_line_a | input | 13 | First active line |
| cfg_line_b | input | 13 | Repeat active line |
| cfg_tog1 | input | 13 | Toggle position 1 |
| cfg_tog2 | input | 13 | Toggle position 2 |
| cfg_tog3 | input | 13 | Toggle position 3 |
| cfg_tog4 | input | 13 | Toggle position 4 |
| v_out | output | 24 | Registered vertical outputs |

## Verification
The assertions assume that `vd` only ever arrives together with `hd`, so a field always begins at pixel 0 of line 0. They also assume that no line is long enough for the 13-bit pixel count to wrap. The stimulus keeps to both assumptions: every field starts with a combined `hd`/`vd` cycle, and lines are 40 clocks long. Configuration changes in the middle of a field are deliberate, and the assertions on captured state treat such changes as legal input.

// File: rtl/sg_pulse_gen.sv
module sg_pulse_gen #(
  parameter int NOUT = 24,
  parameter int CW   = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hd,
  input  logic            vd,
  input  logic [NOUT-1:0] xv_in,
  input  logic [NOUT-1:0] cfg_sel,
  input  logic [NOUT-1:0] cfg_pat,
  input  logic [NOUT-1:0] cfg_mask,
  input  logic [NOUT-1:0] cfg_pol,
  input  logic [CW-1:0]   cfg_line_a,
  input  logic [CW-1:0]   cfg_line_b,
  input  logic [CW-1:0]   cfg_tog1,
  input  logic [CW-1:0]   cfg_tog2,
  input  logic [CW-1:0]   cfg_tog3,
  input  logic [CW-1:0]   cfg_tog4,
  output logic [NOUT-1:0] v_out
);

  logic [CW-1:0]   pix, line;
  logic [NOUT-1:0] sel_q, pat_q, msk_q, pol_q;
  logic [CW-1:0]   la_q, lb_q, t1_q, t2_q, t3_q, t4_q;
  logic [NOUT-1:0] nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= '0;
    end else begin
      pix <= hd ? '0 : pix + 1'b1;
      if (vd)      line <= '0;
      else if (hd) line <= line + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; pat_q <= '0; msk_q <= '0; pol_q <= '0;
      la_q  <= '0; lb_q  <= '0;
      t1_q  <= '0; t2_q  <= '0; t3_q <= '0; t4_q <= '0;
    end else if (vd) begin
      sel_q <= cfg_sel;    pat_q <= cfg_pat;
      msk_q <= cfg_mask;   pol_q <= cfg_pol;
      la_q  <= cfg_line_a; lb_q  <= cfg_line_b;
      t1_q  <= cfg_tog1;   t2_q  <= cfg_tog2;
      t3_q  <= cfg_tog3;   t4_q  <= cfg_tog4;
    end
  end

  wire on_line = (line == la_q) || (line == lb_q);

  wire win_a = (pix >= t1_q) && (pix < t2_q);
  wire win_b = (pix >= t3_q) && (pix < t4_q);

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    wire inv = on_line && !msk_q[i] && (pat_q[i] ? win_b : win_a);
    assign nxt[i] = sel_q[i] ? (pol_q[i] ^ inv) : xv_in[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= '0;
    else        v_out <= nxt;
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((v_out ^ $past(xv_in)) & ~$past(sel_q)) == '0);

  p_pix_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hd |=> pix == '0);

  p_pix_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hd |=> pix == $past(pix) + 1'b1);

  p_line_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vd |=> line == '0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(line != la_q && line != lb_q))
      |-> ((v_out ^ $past(pol_q)) & $past(sel_q)) == '0);

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((v_out ^ $past(pol_q)) & $past(sel_q) & $past(msk_q)) == '0);

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vd |=> $stable(sel_q) && $stable(msk_q) && $stable(pol_q) && $stable(pat_q));

  always_comb if (!rst_n) p_reset_r1: assert (v_out == '0);

endmodule

// File: tb/sg_pulse_gen_bench.sv
module sg_pulse_gen_bench;
  localparam int N = 24;
  localparam int W = 13;
  localparam int LINE_LEN = 40;
  localparam int LINES = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd = 1'b0, vd = 1'b0;
  logic [N-1:0] xv_in = '0, cfg_sel = '0, cfg_pat = '0, cfg_mask = '0, cfg_pol = '0;
  logic [W-1:0] cfg_line_a = '0, cfg_line_b = '0;
  logic [W-1:0] cfg_tog1 = '0, cfg_tog2 = '0, cfg_tog3 = '0, cfg_tog4 = '0;
  logic [N-1:0] v_out;

  always #2 clk = ~clk;

  sg_pulse_gen u_sg_pulse_gen (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .xv_in(xv_in),
    .cfg_sel(cfg_sel), .cfg_pat(cfg_pat), .cfg_mask(cfg_mask), .cfg_pol(cfg_pol),
    .cfg_line_a(cfg_line_a), .cfg_line_b(cfg_line_b),
    .cfg_tog1(cfg_tog1), .cfg_tog2(cfg_tog2), .cfg_tog3(cfg_tog3), .cfg_tog4(cfg_tog4),
    .v_out(v_out)
  );

  int checks = 0, errors = 0;
  string tag = "R8";
  logic [N-1:0] exp_q[$];
  string tag_q[$];
  logic armed = 1'b0;

  logic [W-1:0] m_pix = '0, m_line = '0;
  logic [N-1:0] m_sel = '0, m_pat = '0, m_msk = '0, m_pol = '0;
  logic [W-1:0] m_la = '0, m_lb = '0, m_t1 = '0, m_t2 = '0, m_t3 = '0, m_t4 = '0;

  function automatic logic [N-1:0] predict();
    logic [N-1:0] e;
    logic on;
    on = (m_line == m_la) || (m_line == m_lb);
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] a, b;
      logic inv;
      a = m_pat[i] ? m_t3 : m_t1;
      b = m_pat[i] ? m_t4 : m_t2;
      inv = on && !m_msk[i] && (m_pix >= a) && (m_pix < b);
      e[i] = m_sel[i] ? (m_pol[i] ^ inv) : xv_in[i];
    end
    return e;
  endfunction

  task automatic step(input logic h, input logic v);
    @(negedge clk);
    hd = h; vd = v;
    xv_in = N'($urandom);
    exp_q.push_back(predict());
    tag_q.push_back(tag);
    if (v) begin
      m_sel = cfg_sel; m_pat = cfg_pat; m_msk = cfg_mask; m_pol = cfg_pol;
      m_la = cfg_line_a; m_lb = cfg_line_b;
      m_t1 = cfg_tog1; m_t2 = cfg_tog2; m_t3 = cfg_tog3; m_t4 = cfg_tog4;
    end
    m_pix = h ? '0 : m_pix + 1'b1;
    if (v) m_line = '0;
    else if (h) m_line = m_line + 1'b1;
  endtask

  task automatic run_field(input int mid_line, input logic [N-1:0] mid_sel);
    for (int l = 0; l < LINES; l++) begin
      if (l == mid_line) begin
        cfg_sel = mid_sel;
        cfg_mask = ~cfg_mask;
        cfg_pol = ~cfg_pol;
        cfg_line_a = 3'd3;
      end
      for (int p = 0; p < LINE_LEN; p++) step(p == 0, (p == 0) && (l == 0));
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (armed && exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (v_out !== e) begin
        errors++;
        $display("FAIL %s: v_out=%h expected=%h at %0t", t, v_out, e, $time);
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    xv_in = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (v_out !== '0) begin
      errors++;
      $display("FAIL R1: v_out=%h expected=%h", v_out, {N{1'b0}});
    end
    rst_n = 1'b1;
    armed = 1'b1;

    tag = "R2";
    cfg_sel = '0;
    run_field(-1, '0);

    tag = "R4/R5/R3";
    cfg_sel = 24'hFF0F0F; cfg_pat = 24'h0F00FF; cfg_mask = '0; cfg_pol = 24'hA5A55A;
    cfg_line_a = 13'd2; cfg_line_b = 13'd2;
    cfg_tog1 = 13'd5; cfg_tog2 = 13'd10; cfg_tog3 = 13'd20; cfg_tog4 = 13'd30;
    run_field(-1, '0);
    run_field(-1, '0);

    tag = "R5";
    cfg_line_b = 13'd4;
    run_field(-1, '0);
    cfg_line_b = 13'd8191;
    run_field(-1, '0);

    tag = "R6";
    cfg_sel = '1; cfg_mask = 24'h3C00C3;
    run_field(-1, '0);

    tag = "R7";
    cfg_mask = '0; cfg_line_a = 13'd1; cfg_line_b = 13'd1;
    run_field(2, 24'h00FFFF);
    run_field(-1, '0);

    tag = "R9";
    cfg_sel = '1; cfg_pat = 24'h00FF00; cfg_mask = '0;
    cfg_tog1 = 13'd12; cfg_tog2 = 13'd12; cfg_tog3 = 13'd25; cfg_tog4 = 13'd3;
    cfg_line_a = 13'd0; cfg_line_b = 13'd5;
    run_field(-1, '0);

    tag = "R8";
    cfg_tog1 = 13'd0; cfg_tog2 = 13'd1; cfg_tog3 = 13'd38; cfg_tog4 = 13'd40;
    run_field(-1, '0);

    step(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule